// File: doc/BRIEF.md
# I2C Master Command and Byte Engine

This block is the bus-facing core of an I2C controller. Software drives it through four byte-wide registers: control, data, status and interrupt enable. A write to the control register can ask for a START, a repeated START or a STOP condition. A write to the data register sends one byte. After the byte, the block samples the acknowledge bit on the ninth clock pulse.

SCL and SDA are driven as open-drain enables, where a 1 pulls the line low. The bus timing is built from a quarter-bit tick whose length is set by a parameter. A busy flag covers every operation. A sticky session-done flag is set when an operation finishes, and it can raise an interrupt.

Software waits for busy to fall before each write. It then reads the NAK state back from the control register.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, both line enables are 0 (lines released), control, status and interrupt-enable registers read 0, and irq is 0.
- R2: Control write (address 0) with bit 0 = 1, bits 2:1 = 1 and bit 3 = 0 generates a START: SDA falls while SCL is high, then SCL is pulled low and stays low after completion.
- R3: The same write with bit 3 = 1 generates a repeated START from a low SCL: SDA is released, SCL is released (one rising edge), SDA falls while SCL is high, then SCL is pulled low.
- R4: A data write (address 1) while enabled and idle sends the byte MSB first on nine SCL pulses. During a byte, SDA never changes while SCL stays high, and SDA is released on the ninth pulse.
- R5: SDA is sampled during the ninth SCL high phase. Control bit 3 then reads 1 for NAK (SDA high) and 0 for ACK (SDA low). It changes only during a byte transfer.
- R6: Control bits 2:1 = 2 generate a STOP: SDA rises while SCL is high, both lines end released, and busy stays high for at least one bit period (4 quarter ticks) after SDA rises.
- R7: Status bit 7 (busy) goes high the cycle after an accepted launching write and stays high until the operation finishes. The lines never move while the block is idle.
- R8: Status bit 3 (done) is set when any operation finishes. Writing 1 to status bit 3 clears it, and writing 0 leaves it set. irq equals done AND interrupt-enable bit 3 (address 3).
- R9: Data or control writes while busy is high are ignored: the byte on the bus is the one first written, and no extra condition is generated.
- R10: A control write with bits 2:1 = 0 launches nothing and leaves the engine idle and enabled. A control write with bit 0 = 0 launches nothing and disables the engine. A data write while disabled launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 data, 2 status, 3 interrupt enable |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (same map) |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Interrupt request (done AND enable) |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the engine with QTR_CYCLES = 4, so one bit period is 16 clocks and one byte with its acknowledge takes 144 clocks. That keeps several full sequences short: START, bytes with ACK and with NAK, repeated START, STOP, and then START again from an idle bus. With so few cycles per bit, a write that lands in the middle of a transfer is easy to place. The one-bit-period wait after STOP can also be measured exactly against the 16-clock bound.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_STOP    = 2'd2,
    OP_BYTE    = 2'd3
  } bus_op_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_DATA = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;
  localparam logic [1:0] ADR_IEN  = 2'd3;

  localparam int          STEP_W   = 6;
  localparam logic [5:0]  ACK_STEP = 6'd33;

  // final quarter step of each operation
  function automatic logic [5:0] last_step(bus_op_e op);
    case (op)
      OP_START, OP_RESTART: last_step = 6'd3;
      OP_STOP:              last_step = 6'd7;
      default:              last_step = 6'd35;
    endcase
  endfunction

  // line enables {scl_low, sda_low} for a given operation step
  function automatic logic [1:0] line_drive(bus_op_e op, logic [5:0] step,
                                            logic [7:0] d);
    logic [3:0] bitn;
    logic [1:0] q;
    logic       sl;
    bitn = step[5:2];
    q    = step[1:0];
    sl   = 1'b0;
    case (op)
      OP_START: begin
        case (step)
          6'd0:       line_drive = 2'b00;
          6'd1, 6'd2: line_drive = 2'b01;
          default:    line_drive = 2'b11;
        endcase
      end
      OP_RESTART: begin
        case (step)
          6'd0:    line_drive = 2'b10;
          6'd1:    line_drive = 2'b00;
          6'd2:    line_drive = 2'b01;
          default: line_drive = 2'b11;
        endcase
      end
      OP_STOP: begin
        case (step)
          6'd0:    line_drive = 2'b11;
          6'd1:    line_drive = 2'b01;
          default: line_drive = 2'b00;
        endcase
      end
      default: begin
        if (bitn < 4'd8) sl = ~d[~step[4:2]];
        line_drive = {(q == 2'd0) || (q == 2'd3), sl};
      end
    endcase
  endfunction

  function automatic logic cmd_launches(logic [1:0] cmd);
    return (cmd == 2'd1) || (cmd == 2'd2);
  endfunction

  function automatic bus_op_e cmd_to_op(logic [1:0] cmd, logic again);
    if (cmd == 2'd2) return OP_STOP;
    return again ? OP_RESTART : OP_START;
  endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QTR_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] TOP = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bus_seq.sv
module i2c_bus_seq
  import i2c_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  bus_op_e    launch_op,
  input  logic [7:0] launch_data,
  input  logic       tick,
  input  logic       sda_in,
  output logic       busy,
  output logic       nak,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       seq_done,
  output logic       cond_phase,
  output logic       byte_is_op,
  output logic [7:0] cur_byte
);
  bus_op_e           op;
  logic [STEP_W-1:0] step;
  logic              at_end;
  logic [1:0]        drive;

  assign at_end     = (step == last_step(op));
  assign seq_done   = busy && tick && at_end;
  assign cond_phase = busy && (op != OP_BYTE);
  assign byte_is_op = (op == OP_BYTE);
  assign drive      = line_drive(op, step, cur_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      op       <= OP_START;
      step     <= '0;
      cur_byte <= '0;
      nak      <= 1'b0;
    end else if (!busy) begin
      if (launch) begin
        busy <= 1'b1;
        op   <= launch_op;
        step <= '0;
        if (launch_op == OP_BYTE) cur_byte <= launch_data;
      end
    end else if (tick) begin
      if (op == OP_BYTE && step == ACK_STEP) nak <= sda_in;
      if (at_end) busy <= 1'b0;
      else        step <= step + 1'b1;
    end
  end

  // registered line enables, held while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (busy) begin
      scl_oe <= drive[1];
      sda_oe <= drive[0];
    end
  end
endmodule

// File: rtl/i2c_regs.sv
module i2c_regs
  import i2c_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       busy,
  input  logic       nak,
  input  logic       seq_done,
  output logic       done_flag,
  output logic       irq,
  output logic       launch,
  output bus_op_e    launch_op,
  output logic [7:0] launch_data
);
  logic       en;
  logic [1:0] cmd;
  logic       ien;
  logic       ctrl_wr, data_wr, stat_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL) && !busy;
  assign data_wr = wr_en && (wr_addr == ADR_DATA) && !busy && en;
  assign stat_wr = wr_en && (wr_addr == ADR_STAT);

  always_comb begin
    launch      = 1'b0;
    launch_op   = OP_BYTE;
    launch_data = wr_data;
    if (ctrl_wr && wr_data[0] && cmd_launches(wr_data[2:1])) begin
      launch    = 1'b1;
      launch_op = cmd_to_op(wr_data[2:1], wr_data[3]);
    end else if (data_wr) begin
      launch    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      cmd       <= 2'd0;
      ien       <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en  <= wr_data[0];
        cmd <= wr_data[2:1];
      end
      if (wr_en && wr_addr == ADR_IEN) ien <= wr_data[3];
      if (seq_done)                    done_flag <= 1'b1;
      else if (stat_wr && wr_data[3])  done_flag <= 1'b0;
    end
  end

  assign irq = done_flag & ien;

  always_comb begin
    case (rd_addr)
      ADR_CTRL: rd_data = {4'b0, nak, cmd, en};
      ADR_STAT: rd_data = {busy, 3'b0, done_flag, 3'b0};
      ADR_IEN:  rd_data = {4'b0, ien, 3'b0};
      default:  rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_eng_pkg::*;
#(
  parameter int QTR_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic       busy, nak, seq_done, cond_phase, byte_is_op, tick;
  logic       done_flag, launch;
  bus_op_e    launch_op;
  logic [7:0] launch_data, cur_byte;

  i2c_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .nak(nak), .seq_done(seq_done), .done_flag(done_flag),
    .irq(irq), .launch(launch), .launch_op(launch_op),
    .launch_data(launch_data)
  );

  i2c_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  i2c_bus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
    .launch_data(launch_data), .tick(tick), .sda_in(sda_in),
    .busy(busy), .nak(nak), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .seq_done(seq_done), .cond_phase(cond_phase),
    .byte_is_op(byte_is_op), .cur_byte(cur_byte)
  );
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       busy,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       cond_phase,
  input logic       byte_is_op,
  input logic       seq_done,
  input logic       done_flag,
  input logic       nak,
  input logic [7:0] cur_byte
);
  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));

  // R4
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !cond_phase && $past(!cond_phase))
      |-> $stable(sda_oe));

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> done_flag);

  // R9
  byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 2'd1) |=> $stable(cur_byte));

  // R5
  nak_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nak) |-> $past(busy && byte_is_op));
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe), .cond_phase(cond_phase),
  .byte_is_op(byte_is_op), .seq_done(seq_done), .done_flag(done_flag),
  .nak(nak), .cur_byte(cur_byte)
);

// File: tb/i2c_cmd_engine_test.sv
module i2c_cmd_engine_test;
  localparam int QTR = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       irq, scl_oe, sda_oe, sda_in;

  int  total = 0, bad = 0;
  int  start_cnt = 0, stop_cnt = 0, rise_cnt = 0, fall_cnt = 0;
  int  fall_base = 0;
  logic ack_ok = 1'b1;
  logic [8:0] bits = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic tgt_low;
  logic scl_line, sda_line;

  always #2 clk = ~clk;

  assign tgt_low  = ack_ok && ((fall_cnt - fall_base) == 8);
  assign sda_in   = ~(sda_oe | tgt_low);
  assign scl_line = ~scl_oe;
  assign sda_line = sda_in;

  i2c_cmd_engine #(.QTR_CYCLES(QTR)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // bus monitor
  always @(negedge clk) begin
    if (scl_line && prev_scl) begin
      if (prev_sda && !sda_line) start_cnt <= start_cnt + 1;
      if (!prev_sda && sda_line) stop_cnt  <= stop_cnt + 1;
    end
    if (scl_line && !prev_scl) begin
      bits     <= {bits[7:0], sda_line};
      rise_cnt <= rise_cnt + 1;
    end
    if (!scl_line && prev_scl) fall_cnt <= fall_cnt + 1;
    prev_scl <= scl_line;
    prev_sda <= sda_line;
  end

  task automatic check(input logic ok, input string tag, input int act,
                       input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_idle;
    logic [7:0] v;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd(2'd2, v);
      if (!v[7]) break;
    end
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 0);
    rd(2'd2, v); check(v == 8'h00, "R1 status", v, 0);
    rd(2'd3, v); check(v == 8'h00, "R1 ien", v, 0);
    check(!irq && !scl_oe && !sda_oe, "R1 lines/irq",
          {irq, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_start;
    logic [7:0] v;
    int s0;
    s0 = start_cnt;
    wr(2'd0, 8'h03);
    rd(2'd2, v); check(v[7] == 1'b1, "R7 busy after start write", v, 8'h80);
    wait_idle();
    check(start_cnt == s0 + 1, "R2 start seen", start_cnt - s0, 1);
    check(scl_oe == 1'b1, "R2 scl held low", scl_oe, 1);
    rd(2'd2, v); check(v == 8'h08, "R8 done set", v, 8'h08);
  endtask

  task automatic t_done_clear;
    logic [7:0] v;
    check(irq == 1'b1, "R8 irq with enable", irq, 1);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check(v[3] == 1'b1, "R8 write 0 keeps", v, 8'h08);
    wr(2'd2, 8'h08);
    rd(2'd2, v); check(v[3] == 1'b0, "R8 write 1 clears", v, 0);
    check(irq == 1'b0, "R8 irq cleared", irq, 0);
  endtask

  task automatic t_byte(input logic [7:0] d, input logic ack,
                        input logic disturb);
    logic [7:0] v;
    int r0, s0, p0;
    ack_ok    = ack;
    fall_base = fall_cnt;
    r0 = rise_cnt; s0 = start_cnt; p0 = stop_cnt;
    wr(2'd1, d);
    if (disturb) begin
      repeat (20) @(negedge clk);
      wr(2'd1, ~d);
      wr(2'd0, 8'h05);
    end
    wait_idle();
    check(rise_cnt == r0 + 9, "R4 nine pulses", rise_cnt - r0, 9);
    check(bits[8:1] == d, disturb ? "R9 byte kept" : "R4 msb first",
          bits[8:1], d);
    check(start_cnt == s0 && stop_cnt == p0,
          disturb ? "R9 no extra condition" : "R4 sda stable high scl",
          (start_cnt - s0) + (stop_cnt - p0), 0);
    rd(2'd0, v);
    check(v[3] == !ack, "R5 nak readback", v[3], !ack);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_restart;
    int s0, r0;
    s0 = start_cnt; r0 = rise_cnt;
    wr(2'd0, 8'h0B);
    wait_idle();
    check(start_cnt == s0 + 1, "R3 restart seen", start_cnt - s0, 1);
    check(rise_cnt == r0 + 1, "R3 scl released once", rise_cnt - r0, 1);
    check(scl_oe == 1'b1, "R3 scl low after", scl_oe, 1);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_stop;
    logic [7:0] v;
    int p0, after;
    logic seen;
    p0 = stop_cnt; after = 0; seen = 1'b0;
    wr(2'd0, 8'h05);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      rd(2'd2, v);
      if (!v[7]) break;
      if (stop_cnt != p0) seen = 1'b1;
      if (seen) after++;
    end
    check(stop_cnt == p0 + 1, "R6 stop seen", stop_cnt - p0, 1);
    check(after >= 4 * QTR, "R6 busy after stop", after, 4 * QTR);
    check(!scl_oe && !sda_oe, "R6 lines released", {scl_oe, sda_oe}, 0);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_noaction;
    logic [7:0] v;
    int s0;
    s0 = start_cnt;
    wr(2'd0, 8'h01);
    rd(2'd2, v); check(v[7] == 1'b0, "R10 no-action idle", v, 0);
    rd(2'd0, v); check(v[2:0] == 3'b001, "R10 enabled idle", v[2:0], 1);
    wr(2'd0, 8'h02);
    rd(2'd2, v); check(v[7] == 1'b0, "R10 disabled start ignored", v, 0);
    wr(2'd1, 8'h55);
    rd(2'd2, v); check(v[7] == 1'b0, "R10 data while disabled", v, 0);
    repeat (40) @(negedge clk);
    check(start_cnt == s0 && !scl_oe && !sda_oe, "R10 bus untouched",
          start_cnt - s0, 0);
    rd(2'd0, v); check(v[0] == 1'b0, "R10 enable cleared", v[0], 0);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (2000 * 50) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr(2'd3, 8'h08);
    t_start();
    t_done_clear();
    t_byte(8'hA5, 1'b1, 1'b0);
    t_byte(8'h3C, 1'b0, 1'b1);
    t_restart();
    t_byte(8'h81, 1'b1, 1'b0);
    t_stop();
    t_start();
    wr(2'd2, 8'h08);
    t_byte(8'h6E, 1'b1, 1'b0);
    t_stop();
    t_noaction();
    summary();
    $finish;
  end
endmodule